// File: doc/BRIEF.md
# Serial Port Control Register Bank

This block is the register file of a serial port. It stores the six writable control words of the port (global control, two general control words, two line-control words and the interrupt word) and returns them, together with five read-only words, over a simple single-cycle bus. A write strobe, an address and a data word arrive in one cycle. The low two address bits of the word offset pick the operation, so software can load a whole register, or OR, clear or flip selected bits of it, without a read-modify-write.

Bit 31 of the global control word is a soft reset. While it reads as one, every other writable register is held at zero and ignores writes. Software drops the soft reset, polls until it reads zero, then drops the clock-gate bit (bit 30). Reads are combinational from the registered state, so a value written at one clock edge can be read in the next cycle. The serial engine drives the read-only words and uses the decoded control-2 bits.

Top module: `serial_regbank`

## Requirements
- R1: After the asynchronous reset, the global control word (slot 0x00) reads 0xC0000000 and the other five writable registers read 0.
- R2: For a writable slot at base B, a write to B+0x0 loads the data, B+0x4 ORs it in, B+0x8 clears the bits set in the data, and B+0xC XORs it in. The new value is visible from the cycle after the write edge.
- R3: The writable registers sit at 0x00 (global control), 0x10 (control 1), 0x20 (control 2), 0x30 (line control), 0x40 (line control 2) and 0x50 (interrupt). Each is driven continuously on its own output port.
- R4: When bit 31 of global control is one after a clock edge, including the edge of the write that sets it, the other five registers are zero after that edge, and writes to them are ignored. The global control word stays writable.
- R5: A write that clears bit 31 makes it read zero in the next cycle. Later writes to the other registers take effect again.
- R6: A read at any of the four offsets of a slot returns that slot's value.
- R7: Slots 0x60, 0x70, 0x80 and 0xA0 return the inputs rxDataIn, statusIn, debugIn and autobaudIn. Writes to these slots, to 0x90 and to 0xB0–0xF0 change no writable register.
- R8: Slot 0x90 returns {major[31:24], minor[23:16], step[15:0]} taken from parameters (defaults 3, 1, 0x0007).
- R9: Reads of 0xB0–0xF0 return zero.
- R10: The decoded outputs follow the registers. Soft reset is global control bit 31 and clock gate is bit 30. From control 2: CTS flow enable is bit 15, RTS is bit 11, receive enable is bit 9, transmit enable is bit 8 and port enable is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for this cycle |
| addr | input | 8 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| rxDataIn | input | 32 | Value returned at slot 0x60 |
| statusIn | input | 32 | Value returned at slot 0x70 |
| debugIn | input | 32 | Value returned at slot 0x80 |
| autobaudIn | input | 32 | Value returned at slot 0xA0 |
| ctrl0Out | output | 32 | Global control register |
| ctrl1Out | output | 32 | Control 1 register |
| ctrl2Out | output | 32 | Control 2 register |
| lineCtrlOut | output | 32 | Line control register |
| lineCtrl2Out | output | 32 | Line control 2 register |
| intrOut | output | 32 | Interrupt register |
| softRstOut | output | 1 | Soft reset bit |
| clkGateOut | output | 1 | Clock gate bit |
| portEnOut | output | 1 | Port enable |
| txEnOut | output | 1 | Transmit enable |
| rxEnOut | output | 1 | Receive enable |
| rtsOut | output | 1 | RTS level |
| ctsFlowEnOut | output | 1 | CTS flow-control enable |

## Verification
A write changes a register at the clock edge on which wrEn is high. The register output ports and the read data then show the new value in the cycle after that edge. A read is purely combinational and needs no clock edge. The bench drives each access just after a falling edge and samples two time units later, which is before the next rising edge. For a write, the model is updated at once and the ports are compared at the following falling edge. This places every comparison exactly one register stage after the write that caused it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int SLOT_W    = ADDR_W - 4;
  localparam int NUM_RW    = 6;
  localparam int SRST_BIT  = 31;
  localparam int CGATE_BIT = 30;
  localparam logic [DATA_W-1:0] CTRL0_RST = (DATA_W'(1) << SRST_BIT) | (DATA_W'(1) << CGATE_BIT);

  localparam logic [SLOT_W-1:0] SLOT_DATA  = SLOT_W'(6);
  localparam logic [SLOT_W-1:0] SLOT_STAT  = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_DEBUG = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] SLOT_VER   = SLOT_W'(9);
  localparam logic [SLOT_W-1:0] SLOT_ABAUD = SLOT_W'(10);

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } regOp_e;

  typedef struct packed {
    logic [NUM_RW-1:0] hit;
    regOp_e            op;
  } wrStrobe_t;

  function automatic logic [DATA_W-1:0] applyOp(regOp_e op, logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] d);
    case (op)
      OP_WRITE:  return d;
      OP_SET:    return cur | d;
      OP_CLEAR:  return cur & ~d;
      default:   return cur ^ d;
    endcase
  endfunction
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobe_t         stb,
  output logic [SLOT_W-1:0] rdSlot
);
  logic [SLOT_W-1:0] slot;
  assign slot   = addr[ADDR_W-1:4];
  assign rdSlot = slot;

  always_comb begin
    stb.op  = regOp_e'(addr[3:2]);
    stb.hit = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (wrEn && (slot == SLOT_W'(i))) stb.hit[i] = 1'b1;
    end
  end

  // R3: at most one register strobed per write
  always_comb begin
    p_single_hit_r3: assert ($onehot0(stb.hit));
  end
  // R7: a write to a slot at or above the read-only range hits nothing
  always_comb begin
    if (wrEn && (slot >= SLOT_W'(NUM_RW))) p_ro_no_hit_r7: assert (stb.hit == '0);
  end
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_WORD = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  wrStrobe_t                      stb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [SLOT_W-1:0]              rdSlot,
  input  logic [DATA_W-1:0]              rxDataIn,
  input  logic [DATA_W-1:0]              statusIn,
  input  logic [DATA_W-1:0]              debugIn,
  input  logic [DATA_W-1:0]              autobaudIn,
  output logic [NUM_RW-1:0][DATA_W-1:0]  regQ,
  output logic [DATA_W-1:0]              rdData
);
  logic [DATA_W-1:0] ctrl0Next;
  logic              holdNext;

  assign ctrl0Next = stb.hit[0] ? applyOp(stb.op, regQ[0], wrData) : regQ[0];
  assign holdNext  = ctrl0Next[SRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ[0] <= CTRL0_RST;
    else       regQ[0] <= ctrl0Next;
  end

  for (genvar i = 1; i < NUM_RW; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            regQ[i] <= '0;
      else if (holdNext)    regQ[i] <= '0;
      else if (stb.hit[i])  regQ[i] <= applyOp(stb.op, regQ[i], wrData);
    end

    // R2: set and clear aliases act on the previous value
    p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      (stb.hit[i] && stb.op == OP_SET && !holdNext) |=>
        regQ[i] == ($past(regQ[i]) | $past(wrData)));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
      (stb.hit[i] && stb.op == OP_CLEAR && !holdNext) |=>
        regQ[i] == ($past(regQ[i]) & ~$past(wrData)));
  end

  always_comb begin
    if (rdSlot < SLOT_W'(NUM_RW)) rdData = regQ[rdSlot[$clog2(NUM_RW)-1:0]];
    else begin
      case (rdSlot)
        SLOT_DATA:  rdData = rxDataIn;
        SLOT_STAT:  rdData = statusIn;
        SLOT_DEBUG: rdData = debugIn;
        SLOT_VER:   rdData = VERSION_WORD;
        SLOT_ABAUD: rdData = autobaudIn;
        default:    rdData = '0;
      endcase
    end
  end

  // R4: soft reset visible in a cycle means the other registers are at reset next cycle
  p_srst_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    regQ[0][SRST_BIT] |=> (regQ[NUM_RW-1:1] == '0));
  // R4: while soft reset stays set, the held registers do not move
  p_srst_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[0][SRST_BIT] && holdNext) |=> $stable(regQ[NUM_RW-1:1]));
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import regbank_pkg::*;
#(
  parameter logic [7:0]  VER_MAJOR = 8'd3,
  parameter logic [7:0]  VER_MINOR = 8'd1,
  parameter logic [15:0] VER_STEP  = 16'h0007
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxDataIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] debugIn,
  input  logic [DATA_W-1:0] autobaudIn,
  output logic [DATA_W-1:0] ctrl0Out,
  output logic [DATA_W-1:0] ctrl1Out,
  output logic [DATA_W-1:0] ctrl2Out,
  output logic [DATA_W-1:0] lineCtrlOut,
  output logic [DATA_W-1:0] lineCtrl2Out,
  output logic [DATA_W-1:0] intrOut,
  output logic              softRstOut,
  output logic              clkGateOut,
  output logic              portEnOut,
  output logic              txEnOut,
  output logic              rxEnOut,
  output logic              rtsOut,
  output logic              ctsFlowEnOut
);
  localparam logic [DATA_W-1:0] VERSION_WORD = DATA_W'({VER_MAJOR, VER_MINOR, VER_STEP});

  wrStrobe_t                     stb;
  logic [SLOT_W-1:0]             rdSlot;
  logic [NUM_RW-1:0][DATA_W-1:0] regQ;

  regbank_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .stb    (stb),
    .rdSlot (rdSlot)
  );

  regbank_dp #(.VERSION_WORD(VERSION_WORD)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .rdSlot     (rdSlot),
    .rxDataIn   (rxDataIn),
    .statusIn   (statusIn),
    .debugIn    (debugIn),
    .autobaudIn (autobaudIn),
    .regQ       (regQ),
    .rdData     (rdData)
  );

  assign ctrl0Out     = regQ[0];
  assign ctrl1Out     = regQ[1];
  assign ctrl2Out     = regQ[2];
  assign lineCtrlOut  = regQ[3];
  assign lineCtrl2Out = regQ[4];
  assign intrOut      = regQ[5];

  assign softRstOut   = regQ[0][SRST_BIT];
  assign clkGateOut   = regQ[0][CGATE_BIT];
  assign ctsFlowEnOut = regQ[2][15];
  assign rtsOut       = regQ[2][11];
  assign rxEnOut      = regQ[2][9];
  assign txEnOut      = regQ[2][8];
  assign portEnOut    = regQ[2][0];
endmodule

// File: tb/serial_regbank_test.sv
module serial_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] rxDataIn = 32'h0000_00A5;
  logic [31:0] statusIn = 32'h0800_0000;
  logic [31:0] debugIn = 32'h1234_5678;
  logic [31:0] autobaudIn = 32'h00C0_FFEE;
  logic [31:0] ctrl0Out, ctrl1Out, ctrl2Out, lineCtrlOut, lineCtrl2Out, intrOut;
  logic softRstOut, clkGateOut, portEnOut, txEnOut, rxEnOut, rtsOut, ctsFlowEnOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [6];

  always #10 clk = ~clk;

  serial_regbank uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] opModel(int op, logic [31:0] cur, logic [31:0] d);
    case (op)
      0: return d;
      1: return cur | d;
      2: return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    int s = int'(a[7:4]);
    if (s < 6) return model[s];
    case (s)
      6: return rxDataIn;
      7: return statusIn;
      8: return debugIn;
      9: return {8'd3, 8'd1, 16'h0007};
      10: return autobaudIn;
      default: return 32'h0;
    endcase
  endfunction

  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    int s = int'(a[7:4]);
    int op = int'(a[3:2]);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    if (s == 0) model[0] = opModel(op, model[0], d);
    if (model[0][31]) begin
      for (int i = 1; i < 6; i++) model[i] = '0;
    end else if (s > 0 && s < 6) model[s] = opModel(op, model[s], d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(string req, logic [7:0] a);
    addr = a; wrEn = 1'b0;
    #2;
    check(req, rdData, expRead(a));
  endtask

  task automatic checkPorts(string req);
    check({req, " ctrl0"}, ctrl0Out, model[0]);
    check({req, " ctrl1"}, ctrl1Out, model[1]);
    check({req, " ctrl2"}, ctrl2Out, model[2]);
    check({req, " line"}, lineCtrlOut, model[3]);
    check({req, " line2"}, lineCtrl2Out, model[4]);
    check({req, " intr"}, intrOut, model[5]);
    check("R10 fields", {25'd0, softRstOut, clkGateOut, ctsFlowEnOut, rtsOut, rxEnOut, txEnOut, portEnOut},
          {25'd0, model[0][31], model[0][30], model[2][15], model[2][11], model[2][9], model[2][8], model[2][0]});
  endtask

  initial begin
    int seed = $urandom(32'd20240611);
    model[0] = 32'hC000_0000;
    for (int i = 1; i < 6; i++) model[i] = '0;
    seed = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkPorts("R1");
    doRead("R1 reset ctrl0", 8'h00);
    // R4: writes ignored while soft reset held
    doWrite(8'h20, 32'hFFFF_FFFF);
    checkPorts("R4 ignored");
    // R5: release sequence
    doWrite(8'h08, 32'h8000_0000);
    check("R5 srst reads zero", ctrl0Out, 32'h4000_0000);
    doWrite(8'h08, 32'h4000_0000);
    doRead("R5 ctrl0 clear", 8'h00);
    // R2 / R10: control 2 via aliases
    doWrite(8'h20, 32'h0000_8B01);
    checkPorts("R2 write");
    doWrite(8'h24, 32'h0000_0200);
    checkPorts("R2 set");
    doWrite(8'h28, 32'h0000_0800);
    checkPorts("R2 clear");
    doWrite(8'h2C, 32'h0000_8001);
    checkPorts("R2 toggle");
    // R6 alias reads
    for (int k = 0; k < 4; k++) doRead("R6 alias", 8'h20 + 8'(k*4));
    // R7/R8/R9 read-only and unmapped
    doRead("R7 data", 8'h60);
    doRead("R7 status", 8'h74);
    doRead("R7 debug", 8'h80);
    doRead("R8 version", 8'h9C);
    doRead("R7 autobaud", 8'hA8);
    doRead("R9 unmapped", 8'hF0);
    doWrite(8'h70, 32'hFFFF_FFFF);
    doWrite(8'h90, 32'hFFFF_FFFF);
    doWrite(8'hB4, 32'hFFFF_FFFF);
    checkPorts("R7 ro writes");
    doRead("R8 version after write", 8'h90);
    // R4: setting srst clears others at the same edge
    doWrite(8'h34, 32'h0000_00F0);
    doWrite(8'h04, 32'h8000_0000);
    checkPorts("R4 srst set");
    doWrite(8'h08, 32'hC000_0000);
    doWrite(8'h30, 32'h0000_0070);
    checkPorts("R5 writable again");
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  a = {4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 2'b00};
      logic [31:0] d = $urandom();
      if (a[7:4] == 4'd0 && ($urandom_range(0, 7) != 0)) d[31] = 1'b0;
      if (a[7:4] == 4'd0 && ($urandom_range(0, 3) == 0)) d[31] = 1'b1;
      rxDataIn = $urandom(); statusIn = $urandom();
      doWrite(a, d);
      checkPorts("R2 random");
      doRead("R6 random", {4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 2'b00});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule